// File: doc/BRIEF.md
# Two-Bit Slice Automaton Tile

This block is one small table-driven automaton in a multi-pattern string scanner. Each input character is split into 2-bit slices, and a separate tile follows each slice. This tile sees only its own 2-bit symbol per character. A synchronous table holds up to 256 states. Each state entry carries four next-state pointers, one for each symbol value, and a 16-bit vector with one bit per pattern of the rule group. On every accepted symbol, the tile moves to the pointer that the symbol selects and presents the vector stored with the state it reaches.

A set bit in the vector means only that the pattern is still possible as far as this slice can tell. A real match is the bitwise AND of the vectors from all sibling tiles that watch the other slices of the same character. The table is filled through a configuration write port that is separate from the symbol stream. Each write delivers one whole entry as a 16-bit upper word and a 32-bit lower word.

Top module: `bitslice_fsm_tile`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `cur_state` becomes 0 and `match_vec` becomes 0, whatever the other inputs are.
- R2: At an edge where `sym_valid` is 1 and `cfg_we` is 0, `cur_state` takes pointer number `sym` of the entry of the present state. Pointer k of an entry is bits [8k+7:8k] of the lower word written for that entry.
- R3: At the same edge as an R2 step, `match_vec` takes the upper word (16 bits) written for the entry of the newly reached state.
- R4: At an edge where `sym_valid` is 0, `cur_state` and `match_vec` keep their values.
- R5: At an edge where `cfg_we` and `sym_valid` are both 1, the write is performed, and `cur_state` and `match_vec` keep their values.
- R6: A write at `cfg_addr` with `cfg_hi` and `cfg_lo` replaces that whole entry. A step in the next cycle or any later cycle uses the new pointers and the new vector.
- R7: Rewriting the entry of the present state does not change `match_vec` until the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A 2-bit symbol is presented this cycle |
| sym | input | 2 | The 2-bit slice of the current character |
| cfg_we | input | 1 | Table write request (takes priority over a step) |
| cfg_addr | input | 8 | Entry written |
| cfg_hi | input | 16 | Upper word: pattern vector of the entry |
| cfg_lo | input | 32 | Lower word: four 8-bit next-state pointers |
| cur_state | output | 8 | Current state register, the address of the next lookup |
| match_vec | output | 16 | Pattern vector of the state last reached |

## Verification
The assertions check three things on every cycle. Reset forces both outputs to zero. An idle cycle or a write cycle leaves the state and the vector untouched. Each step lands on the pointer chosen by the multiplexer.

Only the bench scenarios can show that the right pointer and the right vector come from the table for each symbol value. They also show that a freshly written entry is used by the very next step, and that rewriting the present state's entry leaves the output alone until a step occurs. The bench shows these against its own model of the loaded automaton.

// File: rtl/bst_pkg.sv
// Package: default geometry shared by the bit-slice tile modules.
// Assumes: a state pointer indexes the whole table (2**STATE_W entries).
package bst_pkg;
    localparam int DEF_STATE_W = 8;   // pointer width, 256 states
    localparam int DEF_SYM_W   = 2;   // symbol slice width
    localparam int DEF_PMV_W   = 16;  // patterns per rule group
endpackage

// File: rtl/bst_table.sv
// Module: state table of the tile.
// Holds one entry per state as {vector, pointer[NPTR-1] .. pointer[0]}.
// Port A returns the pointer field for the current state; port B returns the
// vector of an arbitrary state (the candidate next state).
// Assumes: the contents are loaded before they are used; the storage is not reset.
module bst_table #(
    parameter int STATE_W = bst_pkg::DEF_STATE_W,
    parameter int SYM_W   = bst_pkg::DEF_SYM_W,
    parameter int PMV_W   = bst_pkg::DEF_PMV_W,
    localparam int NSTATE = 1 << STATE_W,
    localparam int NPTR   = 1 << SYM_W,
    localparam int PTRS_W = NPTR * STATE_W,
    localparam int ENT_W  = PMV_W + PTRS_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [STATE_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic [STATE_W-1:0] raddr_a,
    output logic [PTRS_W-1:0] ptrs_a,
    input  logic [STATE_W-1:0] raddr_b,
    output logic [PMV_W-1:0]  pmv_b
);
    logic [ENT_W-1:0] mem [NSTATE];

    // Write one whole entry per configuration cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read both ports from the stored array.
    always_comb begin
        ptrs_a = mem[raddr_a][PTRS_W-1:0];
        pmv_b  = mem[raddr_b][ENT_W-1:PTRS_W];
    end
endmodule

// File: rtl/bst_step.sv
// Module: next-state selector, a 2**SYM_W-to-1 multiplexer over the pointers.
// Assumes: pointer k occupies bits [k*STATE_W +: STATE_W] of the pointer field.
module bst_step #(
    parameter int STATE_W = bst_pkg::DEF_STATE_W,
    parameter int SYM_W   = bst_pkg::DEF_SYM_W,
    localparam int NPTR   = 1 << SYM_W,
    localparam int PTRS_W = NPTR * STATE_W
) (
    input  logic [PTRS_W-1:0]  ptrs,
    input  logic [SYM_W-1:0]   sym,
    output logic [STATE_W-1:0] nxt
);
    logic [STATE_W-1:0] ptr_arr [NPTR];

    // Unpack the pointer field into one slot per symbol value.
    for (genvar k = 0; k < NPTR; k++) begin : g_unpack
        assign ptr_arr[k] = ptrs[k*STATE_W +: STATE_W];
    end

    // Let the symbol pick its pointer.
    always_comb nxt = ptr_arr[sym];
endmodule

// File: rtl/bitslice_fsm_tile.sv
// Module: one bit-slice automaton tile.
// Each accepted symbol moves the state to the selected pointer of the present
// entry and registers the vector of the state reached. A configuration write
// blocks the step in the same cycle.
// Assumes: synchronous active-low reset; the table is loaded before scanning.
module bitslice_fsm_tile #(
    parameter int STATE_W = bst_pkg::DEF_STATE_W,
    parameter int SYM_W   = bst_pkg::DEF_SYM_W,
    parameter int PMV_W   = bst_pkg::DEF_PMV_W,
    localparam int NPTR   = 1 << SYM_W,
    localparam int PTRS_W = NPTR * STATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid,
    input  logic [SYM_W-1:0]   sym,
    input  logic               cfg_we,
    input  logic [STATE_W-1:0] cfg_addr,
    input  logic [PMV_W-1:0]   cfg_hi,
    input  logic [PTRS_W-1:0]  cfg_lo,
    output logic [STATE_W-1:0] cur_state,
    output logic [PMV_W-1:0]   match_vec
);
    logic [PTRS_W-1:0]  cur_ptrs;
    logic [STATE_W-1:0] nxt_state;
    logic [PMV_W-1:0]   nxt_pmv;
    logic               advance;

    // A step happens only when no write competes for the cycle.
    always_comb advance = sym_valid && !cfg_we;

    bst_table #(.STATE_W(STATE_W), .SYM_W(SYM_W), .PMV_W(PMV_W)) u_table (
        .clk    (clk),
        .we     (cfg_we),
        .waddr  (cfg_addr),
        .wdata  ({cfg_hi, cfg_lo}),
        .raddr_a(cur_state),
        .ptrs_a (cur_ptrs),
        .raddr_b(nxt_state),
        .pmv_b  (nxt_pmv)
    );

    bst_step #(.STATE_W(STATE_W), .SYM_W(SYM_W)) u_step (
        .ptrs(cur_ptrs),
        .sym (sym),
        .nxt (nxt_state)
    );

    // State latch and registered vector of the state reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= '0;
            match_vec <= '0;
        end else if (advance) begin
            cur_state <= nxt_state;
            match_vec <= nxt_pmv;
        end
    end
endmodule

// File: rtl/bst_tile_chk.sv
// Module: cycle checks for bitslice_fsm_tile, attached by bind below.
// Assumes: the same clock and synchronous reset as the tile.
module bst_tile_chk #(
    parameter int STATE_W = bst_pkg::DEF_STATE_W,
    parameter int PMV_W   = bst_pkg::DEF_PMV_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sym_valid,
    input logic               cfg_we,
    input logic [STATE_W-1:0] cur_state,
    input logic [PMV_W-1:0]   match_vec,
    input logic [STATE_W-1:0] step_ptr
);
    // R1: a sampled reset clears both outputs.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (cur_state == '0) && (match_vec == '0));

    // R2: a step lands on the pointer chosen by the multiplexer.
    assert_step_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !cfg_we) |=> cur_state == $past(step_ptr));

    // R4: idle cycles hold the state and the vector.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(cur_state) && $stable(match_vec));

    // R5: a write wins over a symbol in the same cycle.
    assert_write_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && sym_valid) |=> $stable(cur_state) && $stable(match_vec));
endmodule

bind bitslice_fsm_tile bst_tile_chk #(.STATE_W(STATE_W), .PMV_W(PMV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_valid(sym_valid),
    .cfg_we   (cfg_we),
    .cur_state(cur_state),
    .match_vec(match_vec),
    .step_ptr (nxt_state)
);

// File: tb/bitslice_fsm_tile_test.sv
module bitslice_fsm_tile_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;
    // {valid, sym}
    localparam logic [2:0] VEC [NV] = '{
        3'b100, 3'b101, 3'b110, 3'b111, 3'b000, 3'b011, 3'b111, 3'b101,
        3'b100, 3'b010, 3'b110, 3'b110, 3'b111, 3'b001, 3'b100, 3'b101
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0;
    logic [1:0] sym = '0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [15:0] cfg_hi = '0;
    logic [31:0] cfg_lo = '0;
    logic [7:0] cur_state;
    logic [15:0] match_vec;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  mptr [8][4];
    logic [15:0] mpmv [8];
    logic [7:0]  ms;
    logic [15:0] mm;

    bitslice_fsm_tile uut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym(sym),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
        .cur_state(cur_state), .match_vec(match_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [7:0] es, logic [15:0] em);
        n_chk++;
        if (cur_state !== es || match_vec !== em) begin
            n_bad++;
            $display("FAIL %s: state=%0d vec=%h expected state=%0d vec=%h",
                     req, cur_state, match_vec, es, em);
        end
    endtask

    // Drive one cycle from a negedge; return at the next negedge.
    task automatic cyc(logic v, logic [1:0] s, logic w, logic [7:0] a,
                       logic [15:0] h, logic [31:0] l);
        sym_valid = v; sym = s; cfg_we = w; cfg_addr = a; cfg_hi = h; cfg_lo = l;
        @(negedge clk);
        sym_valid = 1'b0; cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] pack(int e);
        return {mptr[e][3], mptr[e][2], mptr[e][1], mptr[e][0]};
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < 8; e++) begin
            for (int k = 0; k < 4; k++) mptr[e][k] = 8'((e * 3 + k + 1) % 8);
            mpmv[e] = 16'h1000 + 16'(e) * 16'h0111;
        end
        @(negedge clk);
        cyc(1'b1, 2'd1, 1'b0, 8'd0, 16'h0, 32'h0);
        @(negedge clk);
        check("R1 reset", 8'd0, 16'h0);
        rst_n = 1'b1;
        // load table; idle writes must leave outputs at zero
        for (int e = 0; e < 8; e++) begin
            cyc(1'b0, 2'd0, 1'b1, 8'(e), mpmv[e], pack(e));
        end
        check("R4 hold during load", 8'd0, 16'h0);
        ms = 8'd0; mm = 16'h0;
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][2], VEC[i][1:0], 1'b0, 8'd0, 16'h0, 32'h0);
            if (VEC[i][2]) begin
                ms = mptr[ms[2:0]][VEC[i][1:0]];
                mm = mpmv[ms[2:0]];
                check("R2/R3 step", ms, mm);
            end else begin
                check("R4 idle", ms, mm);
            end
        end
        // R5: write and symbol together; rewrite the current entry (R7)
        mpmv[ms[2:0]] = 16'hA5A5;
        cyc(1'b1, 2'd2, 1'b1, ms, 16'hA5A5, pack(ms[2:0]));
        check("R5 write priority", ms, mm);
        check("R7 vec unchanged after rewrite", ms, mm);
        // R6: rewrite target of symbol 0, then step there next cycle
        begin
            logic [7:0] tgt;
            tgt = mptr[ms[2:0]][0];
            mpmv[tgt[2:0]] = 16'hBEEF;
            mptr[tgt[2:0]][3] = 8'd6;
            cyc(1'b0, 2'd0, 1'b1, tgt, 16'hBEEF, pack(tgt[2:0]));
            cyc(1'b1, 2'd0, 1'b0, 8'd0, 16'h0, 32'h0);
            ms = tgt; mm = 16'hBEEF;
            check("R6 new vector used", ms, mm);
            cyc(1'b1, 2'd3, 1'b0, 8'd0, 16'h0, 32'h0);
            ms = 8'd6; mm = mpmv[6];
            check("R6 new pointer used", ms, mm);
        end
        // R1: reset from a nonzero state with a symbol present
        rst_n = 1'b0;
        cyc(1'b1, 2'd1, 1'b0, 8'd0, 16'h0, 32'h0);
        check("R1 mid-run reset", 8'd0, 16'h0);
        rst_n = 1'b1;
        cyc(1'b1, 2'd2, 1'b0, 8'd0, 16'h0, 32'h0);
        check("R2 step after reset", mptr[0][2], mpmv[mptr[0][2][2:0]]);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule